// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

This block overlays a 64×64 two-colour cursor on a stream of display pixels. A host loads a 1024-byte pattern memory through a small byte-wide register port. The memory holds two bit planes: a source plane and a mask plane. The host also sets the cursor position, two 24-bit colours and an enable. For each valid pixel, the block compares the raster coordinates supplied by the timing logic against the cursor window. Inside the window it fetches the matching pattern bits and replaces the pixel with the background or foreground colour, or passes it through unchanged.

The host writes the position biased by +64, so the window runs from (position − 64) to (position − 1) on each axis. A cursor can therefore slide partly off the top or left screen edge. New position values are held until the next frame-start pulse, so a cursor never tears mid-frame. Pixel timing comes from outside the block.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, out_valid is 0, the cursor is disabled, both colours are 0 and the active position is 0, so every pixel passes unchanged.
- R2: Each pixel presented with pix_valid high appears on out_rgb with out_valid high exactly one clock later.
- R3: Register select 0 (control) sets pattern load address bits 9:8 from data bits 3:2. Select 1 sets address bits 7:0. Each write to select 2 stores the byte at the load address and then increments the address, wrapping from 1023 to 0.
- R4: Pattern bytes 0–511 are the source plane and bytes 512–1023 are the mask plane. Cursor row r starts at byte r*8 of each plane. Cursor column c lies in byte c/8 at bit 7−(c%8), so the most significant bit comes first.
- R5: Selects 3 and 4 hold X bits 7:0 and X bits 11:8 (data bits 3:0). Selects 5 and 6 do the same for Y. A position value P puts the cursor window at raster coordinates P−64 through P−1.
- R6: Position writes take effect only on the cycle after frame_start is high. Until then, the previous position stays in use.
- R7: Inside the window with the cursor enabled, mask bit 0 passes the input pixel, mask 1 with source 0 outputs the background colour, and mask 1 with source 1 outputs the foreground colour.
- R8: The cursor is enabled when a control write has data bits 1:0 equal to 11 (for example 0x03). Any other value (for example 0x00 or 0x01) disables it, and every pixel then passes unchanged.
- R9: A write to select 7 with value 1 points colour loading at the background, and value 2 points it at the foreground. Each following write to select 8 loads red, then green, then blue (bits 23:16, 15:8, 7:0). After blue, the pointer moves to the next colour slot, so six writes after pointing at 1 load the background and then the foreground.
- R10: Pixels outside the cursor window pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 4 | Host register select |
| host_data | input | 8 | Host write data |
| frame_start | input | 1 | Frame boundary pulse; loads the new position |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_x | input | 12 | Raster column of the input pixel |
| pix_y | input | 12 | Raster row of the input pixel |
| pix_rgb | input | 24 | Input pixel colour |
| out_valid | output | 1 | Output pixel qualifier |
| out_rgb | output | 24 | Output pixel after the cursor overlay |

## Verification
The embedded assertions watch four properties on every cycle:
- the load pointer steps by one per data write;
- the colour pointer moves to the next slot after each blue byte;
- output validity follows input validity with one cycle of latency;
- the active position stays still between frame pulses, and a disabled cursor passes the input pixel.

The directed scenarios cover what needs stored state and geometry:
- the plane layout and MSB-first bit order, shown by a full 64×64 sweep against a bench-side pattern image;
- the exact window edges at P−64 and P−1;
- the load address wrapping across 1023 and the upper address bits;
- the deferred position update;
- the three-way colour decode.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
    localparam int RGB_W = 24;

    typedef enum logic [3:0] {
        SEL_CTRL  = 4'd0,
        SEL_INDEX = 4'd1,
        SEL_DATA  = 4'd2,
        SEL_XLO   = 4'd3,
        SEL_XHI   = 4'd4,
        SEL_YLO   = 4'd5,
        SEL_YHI   = 4'd6,
        SEL_CADDR = 4'd7,
        SEL_CDATA = 4'd8
    } reg_sel_e;

    typedef enum logic [1:0] {
        PX_PASS = 2'd0,
        PX_BG   = 2'd1,
        PX_FG   = 2'd2
    } px_kind_e;

    typedef struct packed {
        logic [RGB_W-1:0] rgb;
        logic             valid;
        logic             en;
        logic             hit;
        logic [2:0]       bit_sel;
    } px_stage_t;

    function automatic px_kind_e classify(logic en, logic hit, logic mask, logic src);
        if (!en || !hit || !mask) return PX_PASS;
        return src ? PX_FG : PX_BG;
    endfunction
endpackage

// File: rtl/cursor_host_regs.sv
module cursor_host_regs
    import cursor_pkg::*;
#(
    parameter int POS_W = 12,
    parameter int AW    = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [3:0]       wr_sel,
    input  logic [7:0]       wr_data,
    output logic             enable,
    output logic             ram_we,
    output logic [AW-1:0]    ram_waddr,
    output logic [7:0]       ram_wdata,
    output logic [POS_W-1:0] xpos,
    output logic [POS_W-1:0] ypos,
    output logic [RGB_W-1:0] bg_rgb,
    output logic [RGB_W-1:0] fg_rgb
);
    localparam int HI_AW  = AW - 8;
    localparam int HI_POS = POS_W - 8;

    logic [AW-1:0] ptr;
    logic [1:0]    cslot;
    logic [1:0]    comp;
    logic          is_data, is_cdata;

    assign is_data   = wr_en && (wr_sel == SEL_DATA);
    assign is_cdata  = wr_en && (wr_sel == SEL_CDATA);
    assign ram_we    = is_data;
    assign ram_waddr = ptr;
    assign ram_wdata = wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= 1'b0;
            ptr    <= '0;
            xpos   <= '0;
            ypos   <= '0;
            cslot  <= '0;
            comp   <= '0;
            bg_rgb <= '0;
            fg_rgb <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_CTRL: begin
                    enable          <= (wr_data[1:0] == 2'b11);
                    ptr[AW-1:8]     <= wr_data[2 +: HI_AW];
                end
                SEL_INDEX: ptr[7:0] <= wr_data;
                SEL_DATA:  ptr      <= ptr + 1'b1;
                SEL_XLO:   xpos[7:0]       <= wr_data;
                SEL_XHI:   xpos[POS_W-1:8] <= wr_data[HI_POS-1:0];
                SEL_YLO:   ypos[7:0]       <= wr_data;
                SEL_YHI:   ypos[POS_W-1:8] <= wr_data[HI_POS-1:0];
                SEL_CADDR: begin
                    cslot <= wr_data[1:0];
                    comp  <= '0;
                end
                SEL_CDATA: begin
                    if (cslot == 2'd1) begin
                        case (comp)
                            2'd0:    bg_rgb[23:16] <= wr_data;
                            2'd1:    bg_rgb[15:8]  <= wr_data;
                            default: bg_rgb[7:0]   <= wr_data;
                        endcase
                    end else if (cslot == 2'd2) begin
                        case (comp)
                            2'd0:    fg_rgb[23:16] <= wr_data;
                            2'd1:    fg_rgb[15:8]  <= wr_data;
                            default: fg_rgb[7:0]   <= wr_data;
                        endcase
                    end
                    if (comp == 2'd2) begin
                        comp  <= '0;
                        cslot <= cslot + 1'b1;
                    end else begin
                        comp  <= comp + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R3
    ld_ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        is_data |=> ptr == $past(ptr) + 1'b1);

    // R9
    color_slot_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (is_cdata && comp == 2'd2) |=> (comp == 2'd0 && cslot == $past(cslot) + 1'b1));
endmodule

// File: rtl/cursor_pattern_ram.sv
module cursor_pattern_ram #(
    parameter int PLANE_BYTES = 512,
    parameter int AW          = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-2:0] raddr,
    output logic [7:0]    src_byte,
    output logic [7:0]    mask_byte
);
    logic [7:0] plane_q [2];

    for (genvar g = 0; g < 2; g++) begin : g_plane
        logic [7:0] mem [PLANE_BYTES];
        logic [7:0] rd_q;
        always_ff @(posedge clk) begin
            if (we && (waddr[AW-1] == 1'(g))) mem[waddr[AW-2:0]] <= wdata;
            rd_q <= mem[raddr];
        end
        assign plane_q[g] = rd_q;
    end

    assign src_byte  = plane_q[0];
    assign mask_byte = plane_q[1];
endmodule

// File: rtl/cursor_pixel_lookup.sv
module cursor_pixel_lookup
    import cursor_pkg::*;
#(
    parameter int POS_W   = 12,
    parameter int CUR_DIM = 64,
    parameter int RA_W    = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [POS_W-1:0] xpos,
    input  logic [POS_W-1:0] ypos,
    input  logic [RGB_W-1:0] bg_rgb,
    input  logic [RGB_W-1:0] fg_rgb,
    input  logic             frame_start,
    input  logic             pix_valid,
    input  logic [POS_W-1:0] pix_x,
    input  logic [POS_W-1:0] pix_y,
    input  logic [RGB_W-1:0] pix_rgb,
    output logic [RA_W-1:0]  rd_addr,
    input  logic [7:0]       src_byte,
    input  logic [7:0]       mask_byte,
    output logic             out_valid,
    output logic [RGB_W-1:0] out_rgb
);
    localparam int OFS_W = $clog2(CUR_DIM);

    logic [POS_W-1:0] x_act, y_act;
    logic [POS_W:0]   sx, sy, dx, dy;
    logic             hit_x, hit_y;
    px_stage_t        st;
    px_kind_e         kind;

    always_comb begin
        sx    = {1'b0, pix_x} + (POS_W+1)'(CUR_DIM);
        sy    = {1'b0, pix_y} + (POS_W+1)'(CUR_DIM);
        dx    = sx - {1'b0, x_act};
        dy    = sy - {1'b0, y_act};
        hit_x = (sx >= {1'b0, x_act}) && (dx < (POS_W+1)'(CUR_DIM));
        hit_y = (sy >= {1'b0, y_act}) && (dy < (POS_W+1)'(CUR_DIM));
        rd_addr = {dy[OFS_W-1:0], dx[OFS_W-1:3]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_act <= '0;
            y_act <= '0;
            st    <= '0;
        end else begin
            if (frame_start) begin
                x_act <= xpos;
                y_act <= ypos;
            end
            st.rgb     <= pix_rgb;
            st.valid   <= pix_valid;
            st.en      <= enable;
            st.hit     <= hit_x && hit_y;
            st.bit_sel <= dx[2:0];
        end
    end

    assign kind = classify(st.en, st.hit, mask_byte[3'd7 - st.bit_sel],
                           src_byte[3'd7 - st.bit_sel]);

    always_comb begin
        case (kind)
            PX_BG:   out_rgb = bg_rgb;
            PX_FG:   out_rgb = fg_rgb;
            default: out_rgb = st.rgb;
        endcase
    end
    assign out_valid = st.valid;

    // R2
    out_lat_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> out_valid);

    // R8
    pass_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !enable) |=> out_rgb == $past(pix_rgb));

    // R6
    pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> ($stable(x_act) && $stable(y_act)));
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int POS_W   = 12,
    parameter int CUR_DIM = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic [3:0]       host_sel,
    input  logic [7:0]       host_data,
    input  logic             frame_start,
    input  logic             pix_valid,
    input  logic [POS_W-1:0] pix_x,
    input  logic [POS_W-1:0] pix_y,
    input  logic [RGB_W-1:0] pix_rgb,
    output logic             out_valid,
    output logic [RGB_W-1:0] out_rgb
);
    localparam int PLANE_BYTES = CUR_DIM * CUR_DIM / 8;
    localparam int AW          = $clog2(2 * PLANE_BYTES);

    logic             enable, ram_we;
    logic [AW-1:0]    ram_waddr;
    logic [7:0]       ram_wdata, src_byte, mask_byte;
    logic [AW-2:0]    rd_addr;
    logic [POS_W-1:0] xpos, ypos;
    logic [RGB_W-1:0] bg_rgb, fg_rgb;

    cursor_host_regs #(.POS_W(POS_W), .AW(AW)) regs_i (
        .clk(clk), .rst(rst), .wr_en(host_wr), .wr_sel(host_sel), .wr_data(host_data),
        .enable(enable), .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
        .xpos(xpos), .ypos(ypos), .bg_rgb(bg_rgb), .fg_rgb(fg_rgb)
    );

    cursor_pattern_ram #(.PLANE_BYTES(PLANE_BYTES), .AW(AW)) ram_i (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr(rd_addr), .src_byte(src_byte), .mask_byte(mask_byte)
    );

    cursor_pixel_lookup #(.POS_W(POS_W), .CUR_DIM(CUR_DIM), .RA_W(AW-1)) look_i (
        .clk(clk), .rst(rst), .enable(enable), .xpos(xpos), .ypos(ypos),
        .bg_rgb(bg_rgb), .fg_rgb(fg_rgb), .frame_start(frame_start),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .pix_rgb(pix_rgb),
        .rd_addr(rd_addr), .src_byte(src_byte), .mask_byte(mask_byte),
        .out_valid(out_valid), .out_rgb(out_rgb)
    );
endmodule

// File: tb/cursor_overlay_tb_top.sv
module cursor_overlay_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [3:0]  host_sel = '0;
    logic [7:0]  host_data = '0;
    logic        frame_start = 1'b0;
    logic        pix_valid = 1'b0;
    logic [11:0] pix_x = '0, pix_y = '0;
    logic [23:0] pix_rgb = '0;
    logic        out_valid;
    logic [23:0] out_rgb;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0]  model [1024];
    int          ld_ptr = 0;
    int          xp_host = 0, yp_host = 0, xp_m = 0, yp_m = 0;
    bit          en_m = 1'b0;
    logic [23:0] bg_m = '0, fg_m = '0;
    int          n_bg = 0, n_fg = 0, n_pass = 0;

    always #4 clk = ~clk;

    cursor_overlay dut_i (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel), .host_data(host_data),
        .frame_start(frame_start), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
        .pix_rgb(pix_rgb), .out_valid(out_valid), .out_rgb(out_rgb)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [3:0] s, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = s; host_data = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic ram_byte(input logic [7:0] d);
        hw(4'd2, d);
        model[ld_ptr] = d;
        ld_ptr = (ld_ptr + 1) % 1024;
    endtask

    task automatic set_pos(input int xp, input int yp);
        hw(4'd3, xp[7:0]); hw(4'd4, {4'h0, xp[11:8]});
        hw(4'd5, yp[7:0]); hw(4'd6, {4'h0, yp[11:8]});
        xp_host = xp; yp_host = yp;
    endtask

    task automatic pulse_frame();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        xp_m = xp_host; yp_m = yp_host;
    endtask

    function automatic logic [23:0] expect_px(int x, int y, logic [23:0] rgb);
        int dx, dy, idx, b;
        dx = x + 64 - xp_m;
        dy = y + 64 - yp_m;
        if (!en_m || dx < 0 || dx >= 64 || dy < 0 || dy >= 64) return rgb;
        idx = dy * 8 + dx / 8;
        b = 7 - (dx % 8);
        if (!model[512 + idx][b]) return rgb;
        return model[idx][b] ? fg_m : bg_m;
    endfunction

    task automatic px(input int x, input int y, input string req);
        logic [23:0] rgb, e;
        rgb = {x[7:0], y[7:0], 8'h5A};
        e = expect_px(x, y, rgb);
        if (e == rgb) n_pass++; else if (e == bg_m) n_bg++; else n_fg++;
        @(negedge clk);
        pix_valid = 1'b1; pix_x = x[11:0]; pix_y = y[11:0]; pix_rgb = rgb;
        @(negedge clk);
        pix_valid = 1'b0;
        check({req, " valid"}, {23'h0, out_valid}, 24'h1);
        check(req, out_rgb, e);
    endtask

    task automatic t_reset();
        check("R1 out_valid", {23'h0, out_valid}, 24'h0);
        px(0, 0, "R1 pass after reset");
        px(10, 20, "R8 disabled pass");
    endtask

    task automatic t_load_and_sweep();
        hw(4'd0, 8'h00); hw(4'd1, 8'h00); ld_ptr = 0;
        for (int i = 0; i < 1024; i++) ram_byte(8'((i * 37) ^ (i >> 3) ^ 8'h6C));
        hw(4'd7, 8'd1);
        hw(4'd8, 8'h11); hw(4'd8, 8'h22); hw(4'd8, 8'h33);
        hw(4'd8, 8'hA0); hw(4'd8, 8'hB0); hw(4'd8, 8'hC0);
        bg_m = 24'h112233; fg_m = 24'hA0B0C0;
        set_pos(164, 114);
        hw(4'd0, 8'h03); en_m = 1'b1;
        pulse_frame();
        for (int y = 50; y < 114; y++)
            for (int x = 100; x < 164; x++) px(x, y, "R7 R4 sweep");
        check("R9 bg seen", {23'h0, n_bg > 0}, 24'h1);
        check("R9 fg seen", {23'h0, n_fg > 0}, 24'h1);
        px(99, 60, "R10 left edge");
        px(164, 60, "R10 right edge");
        px(120, 49, "R10 top edge");
        px(120, 114, "R10 bottom edge");
        px(100, 50, "R5 first corner");
        px(163, 113, "R5 last corner");
    endtask

    task automatic t_known_bits();
        hw(4'd0, 8'h0B); hw(4'd1, 8'h05); ld_ptr = 512 + 5;
        ram_byte(8'h80);
        hw(4'd0, 8'h03); hw(4'd1, 8'h05); ld_ptr = 5;
        ram_byte(8'h80);
        check("R4 model", {16'h0, model[5]}, 24'h80);
        px(140, 50, "R4 msb first fg");
        px(141, 50, "R4 mask clear pass");
        hw(4'd0, 8'h0F); hw(4'd1, 8'hFF); ld_ptr = 1023;
        ram_byte(8'hFF);
        ram_byte(8'h00);
        hw(4'd0, 8'h03);
        px(163, 113, "R3 addr 1023");
        px(100, 50, "R3 wrap to 0");
    endtask

    task automatic t_deferred_pos();
        set_pos(64 + 300, 64 + 200);
        px(100, 50, "R6 old pos held");
        px(300, 200, "R6 new not yet");
        pulse_frame();
        px(100, 50, "R6 old gone");
        for (int x = 300; x < 308; x++) px(x, 200, "R6 new pos row");
        set_pos(0, 0);
        pulse_frame();
        px(0, 0, "R5 offscreen origin");
        set_pos(64 + 300, 64 + 200);
        pulse_frame();
    endtask

    task automatic t_enable_modes();
        hw(4'd0, 8'h00); en_m = 1'b0;
        for (int x = 300; x < 304; x++) px(x, 201, "R8 off 0x00");
        hw(4'd0, 8'h01);
        for (int x = 300; x < 304; x++) px(x, 201, "R8 off 0x01");
        hw(4'd0, 8'h03); en_m = 1'b1;
        for (int x = 300; x < 316; x++) px(x, 201, "R8 on 0x03");
    endtask

    task automatic t_colours();
        hw(4'd7, 8'd2);
        hw(4'd8, 8'h01); hw(4'd8, 8'h02); hw(4'd8, 8'h03);
        fg_m = 24'h010203;
        hw(4'd7, 8'd1);
        hw(4'd8, 8'hEE);
        bg_m[23:16] = 8'hEE;
        for (int x = 300; x < 316; x++) px(x, 202, "R9 colour reload");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load_and_sweep();
        t_known_bits();
        t_deferred_pos();
        t_enable_modes();
        t_colours();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule